// File: doc/BRIEF.md
# Breakpoint Address Matcher

This block checks each memory access, port access or instruction fetch against a small set of programmable breakpoint slots. It reports which slots hit. Each slot holds a linear address, a type code, a length code and an enable bit. Software programs a slot through a plain single-cycle write port.

Accesses arrive on a valid/ready stream. Each access carries an address, a byte count and a kind. The matcher compares the access with every slot in the same cycle. It places the per-slot hit vector and a combined flag in a one-entry output register, which drains through its own valid/ready handshake.

Back-pressure works as follows. The block accepts an access whenever its output register is empty, or is being drained in the same cycle. A result that is not taken stays unchanged, and no new access enters until it is taken.

Top module: `bkpt_match_top`

## Requirements
- R1: After reset every slot is disabled, `res_valid` is 0 and `acc_ready` is 1.
- R2: A slot write (`cfg_we`) loads the slot picked by `cfg_slot`. An access accepted on the same edge as the write is still judged against the old slot contents.
- R3: Slot length codes are 00 = 1 byte, 01 = 2 bytes, 11 = 4 bytes and 10 = 8 bytes. The covered range starts at the slot address with its low 0, 1, 2 or 3 bits forced to zero, respectively.
- R4: A data breakpoint hits when any byte of the access lies inside the slot range. A partial overlap is enough.
- R5: Type 01 hits only write accesses (kind 2). Type 11 hits read (kind 1) and write (kind 2) accesses.
- R6: Type 00 hits only fetch accesses (kind 0) whose address equals the slot address exactly, and only when the slot length code is 00. With any other length code it never hits.
- R7: Type 10 hits only port accesses (kind 3). For those, only the low 16 bits of `acc_addr` are used, zero-extended to 32 bits.
- R8: An access spans `acc_addr` through `acc_addr + acc_len`, where `acc_len` is the byte count minus 1. The span never wraps past 0xFFFFFFFF, so it cannot reach low addresses.
- R9: A slot whose enable bit is 0 never hits.
- R10: The result of an access accepted at one edge is visible after that edge, with `res_valid` = 1. `res_any` is the OR of `res_hit`.
- R11: `acc_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. A result not taken holds steady. While `res_valid` is 0, `res_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | 2 | Slot index to write |
| cfg_addr | input | 32 | Breakpoint address |
| cfg_type | input | 2 | Type code (00 fetch, 01 write, 10 port, 11 read/write) |
| cfg_len | input | 2 | Length code |
| cfg_en | input | 1 | Slot enable |
| acc_valid | input | 1 | Access valid |
| acc_ready | output | 1 | Access accepted when high with acc_valid |
| acc_addr | input | 32 | Access address |
| acc_len | input | 3 | Access byte count minus 1 |
| acc_kind | input | 2 | Access kind (0 fetch, 1 read, 2 write, 3 port) |
| res_ready | input | 1 | Downstream takes the result |
| res_valid | output | 1 | Result present |
| res_hit | output | 4 | Per-slot hit vector, bit n for slot n |
| res_any | output | 1 | Any slot hit |

## Verification
The hardest case to reach from the ports is a slot write on the very edge that accepts an access. The result must reflect the old slot contents. The bench drives the write strobe and the access together in one cycle, then repeats the access alone to see the new contents take effect.

The other hard case is an 8-byte access near the top of the address space with a slot at address 0. That case catches span wrap-around.

A stalled result is exercised by holding `res_ready` low while a second access waits. The bench then checks that the stalled result stays unchanged and that the waiting access enters only once the stall is released.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    BT_EXEC  = 2'b00,
    BT_WRITE = 2'b01,
    BT_PORT  = 2'b10,
    BT_RDWR  = 2'b11
  } bp_type_e;

  typedef enum logic [1:0] {
    AK_FETCH = 2'd0,
    AK_READ  = 2'd1,
    AK_WRITE = 2'd2,
    AK_PORT  = 2'd3
  } acc_kind_e;

  // bytes covered by a length code, minus one
  function automatic logic [2:0] len_span(input logic [1:0] code);
    case (code)
      2'b00:   len_span = 3'd0;
      2'b01:   len_span = 3'd1;
      2'b11:   len_span = 3'd3;
      default: len_span = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/bkpt_slot_file.sv
module bkpt_slot_file #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [SLOT_W-1:0]                sel,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [1:0]                       wr_type,
  input  logic [1:0]                       wr_len,
  input  logic                             wr_en,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0] s_addr,
  output logic [NUM_SLOTS-1:0][1:0]        s_type,
  output logic [NUM_SLOTS-1:0][1:0]        s_len,
  output logic [NUM_SLOTS-1:0]             s_en
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_addr[g] <= '0;
        s_type[g] <= 2'b00;
        s_len[g]  <= 2'b00;
        s_en[g]   <= 1'b0;
      end else if (we && (sel == SLOT_W'(g))) begin
        s_addr[g] <= wr_addr;
        s_type[g] <= wr_type;
        s_len[g]  <= wr_len;
        s_en[g]   <= wr_en;
      end
    end
  end

endmodule

// File: rtl/bkpt_acc_norm.sv
module bkpt_acc_norm #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [1:0]        kind,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W:0]   last_wide
);
  import bkpt_pkg::*;

  always_comb begin
    if (kind == AK_PORT) first = {{(ADDR_W-PORT_W){1'b0}}, raw_addr[PORT_W-1:0]};
    else                 first = raw_addr;
    // one extra bit keeps the span from wrapping to address zero
    last_wide = {1'b0, first} + {{(ADDR_W+1-LEN_W){1'b0}}, len_m1};
  end

endmodule

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              en,
  input  logic [1:0]        btype,
  input  logic [1:0]        blen,
  input  logic [ADDR_W-1:0] baddr,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W:0]   last_wide,
  output logic              hit
);
  import bkpt_pkg::*;

  logic [ADDR_W-1:0] mask, lo, hi;
  logic              overlap, kind_ok, exec_hit;

  always_comb begin
    mask     = {{(ADDR_W-3){1'b0}}, len_span(blen)};
    lo       = baddr & ~mask;
    hi       = lo | mask;
    overlap  = (first <= hi) && (last_wide >= {1'b0, lo});
    exec_hit = (kind == AK_FETCH) && (blen == 2'b00) && (first == baddr);
    case (btype)
      BT_WRITE: kind_ok = (kind == AK_WRITE);
      BT_RDWR:  kind_ok = (kind == AK_READ) || (kind == AK_WRITE);
      BT_PORT:  kind_ok = (kind == AK_PORT);
      default:  kind_ok = 1'b0;
    endcase
    if (!en)                  hit = 1'b0;
    else if (btype == BT_EXEC) hit = exec_hit;
    else                      hit = kind_ok && overlap;
  end

endmodule

// File: rtl/bkpt_result_stage.sv
module bkpt_result_stage #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_SLOTS-1:0] in_hit,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [NUM_SLOTS-1:0] out_hit,
  output logic                 out_any
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= '0;
      out_any   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_hit   <= in_hit;
      out_any   <= |in_hit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_hit   <= '0;
      out_any   <= 1'b0;
    end
  end

endmodule

// File: rtl/bkpt_match_top.sv
module bkpt_match_top #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int PORT_W    = 16,
  parameter int LEN_W     = 3,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [1:0]           cfg_type,
  input  logic [1:0]           cfg_len,
  input  logic                 cfg_en,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [LEN_W-1:0]     acc_len,
  input  logic [1:0]           acc_kind,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [NUM_SLOTS-1:0] res_hit,
  output logic                 res_any
);

  logic [NUM_SLOTS-1:0][ADDR_W-1:0] s_addr;
  logic [NUM_SLOTS-1:0][1:0]        s_type;
  logic [NUM_SLOTS-1:0][1:0]        s_len;
  logic [NUM_SLOTS-1:0]             s_en;
  logic [ADDR_W-1:0]                first;
  logic [ADDR_W:0]                  last_wide;
  logic [NUM_SLOTS-1:0]             hit_now;

  bkpt_slot_file #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_slot),
    .wr_addr(cfg_addr), .wr_type(cfg_type), .wr_len(cfg_len), .wr_en(cfg_en),
    .s_addr(s_addr), .s_type(s_type), .s_len(s_len), .s_en(s_en)
  );

  bkpt_acc_norm #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .LEN_W(LEN_W)) u_norm (
    .raw_addr(acc_addr), .len_m1(acc_len), .kind(acc_kind),
    .first(first), .last_wide(last_wide)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    bkpt_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .en(s_en[g]), .btype(s_type[g]), .blen(s_len[g]), .baddr(s_addr[g]),
      .kind(acc_kind), .first(first), .last_wide(last_wide), .hit(hit_now[g])
    );
  end

  bkpt_result_stage #(.NUM_SLOTS(NUM_SLOTS)) u_res (
    .clk(clk), .rst_n(rst_n), .in_valid(acc_valid), .in_ready(acc_ready),
    .in_hit(hit_now), .out_ready(res_ready), .out_valid(res_valid),
    .out_hit(res_hit), .out_any(res_any)
  );

endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_ready,
  input logic                 res_ready,
  input logic                 res_valid,
  input logic [NUM_SLOTS-1:0] res_hit,
  input logic                 res_any
);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_any)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_hit == '0 && !res_any));

  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> res_valid);

  // R10
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(acc_valid && acc_ready));

  // R10
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_any == (res_hit != '0)));

endmodule

bind bkpt_match_top bkpt_match_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .res_ready(res_ready), .res_valid(res_valid), .res_hit(res_hit), .res_any(res_any)
);

// File: tb/test_bkpt_match_top.sv
`timescale 1ns/1ps
module test_bkpt_match_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [31:0] cfg_addr = '0;
  logic [1:0]  cfg_type = '0;
  logic [1:0]  cfg_len = '0;
  logic        cfg_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_len = '0;
  logic [1:0]  acc_kind = '0;
  logic        res_ready = 1'b1;
  logic        res_valid;
  logic [3:0]  res_hit;
  logic        res_any;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bkpt_match_top i_bkpt_match_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_addr(cfg_addr), .cfg_type(cfg_type), .cfg_len(cfg_len), .cfg_en(cfg_en),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_len(acc_len), .acc_kind(acc_kind), .res_ready(res_ready),
    .res_valid(res_valid), .res_hit(res_hit), .res_any(res_any)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  lenm1;
    logic [1:0]  kind;
    logic [3:0]  exp;
  } vec_t;

  // slots: 0 @A0001 rd/wr 1B, 1 @A0002 wr 1B, 2 @B0002 rd/wr 2B, 3 @C0000 wr 4B
  localparam vec_t VECS [13] = '{
    '{32'h000A0000, 3'd1, 2'd1, 4'b0001},  // R4 partial overlap
    '{32'h000A0000, 3'd3, 2'd2, 4'b0011},  // R4 two slots
    '{32'h000A0002, 3'd0, 2'd1, 4'b0000},  // R5 read vs write-only
    '{32'h000A0002, 3'd0, 2'd2, 4'b0010},  // R5 write hits
    '{32'h000B0001, 3'd1, 2'd1, 4'b0100},  // R4
    '{32'h000B0003, 3'd0, 2'd2, 4'b0100},  // R3 2-byte range end
    '{32'h000B0004, 3'd0, 2'd1, 4'b0000},  // R3 just past
    '{32'h000C0003, 3'd0, 2'd2, 4'b1000},  // R3 4-byte range end
    '{32'h000C0000, 3'd3, 2'd1, 4'b0000},  // R5 read vs write-only
    '{32'h000BFFFC, 3'd7, 2'd2, 4'b1000},  // R4 8-byte access
    '{32'h000C0004, 3'd0, 2'd2, 4'b0000},  // R3 past 4-byte range
    '{32'h000A0001, 3'd0, 2'd3, 4'b0000},  // R7 port kind vs data slot
    '{32'h000A0001, 3'd0, 2'd0, 4'b0000}   // R6 fetch vs data slot
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr_slot(input logic [1:0] s, input logic [31:0] a,
                         input logic [1:0] t, input logic [1:0] l, input logic e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = s; cfg_addr = a; cfg_type = t; cfg_len = l; cfg_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [2:0] lm,
                       input logic [1:0] k, input logic [3:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_len = lm; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {27'd0, res_valid, res_hit}, {27'd0, 1'b1, exp});
    check("R10", {31'd0, res_any}, {31'd0, exp != 4'd0});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {30'd0, res_valid, acc_ready}, {30'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    probe("R1", 32'h000A0001, 3'd0, 2'd2, 4'b0000);

    wr_slot(2'd0, 32'h000A0001, 2'b11, 2'b00, 1'b1);
    wr_slot(2'd1, 32'h000A0002, 2'b01, 2'b00, 1'b1);
    wr_slot(2'd2, 32'h000B0002, 2'b11, 2'b01, 1'b1);
    wr_slot(2'd3, 32'h000C0000, 2'b01, 2'b11, 1'b1);
    foreach (VECS[i]) probe("R4/R5 table", VECS[i].addr, VECS[i].lenm1, VECS[i].kind, VECS[i].exp);

    // R2: write on the accepting edge uses old contents
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h000A0001; acc_len = 3'd0; acc_kind = 2'd1;
    cfg_we = 1'b1; cfg_slot = 2'd0; cfg_addr = 32'h000A0001; cfg_type = 2'b11;
    cfg_len = 2'b00; cfg_en = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b0;
    check("R2 old", {28'd0, res_hit}, 32'h1);
    probe("R9 disabled", 32'h000A0001, 3'd0, 2'd1, 4'b0000);

    // R3 masking of unaligned slot addresses
    wr_slot(2'd0, 32'h00001003, 2'b11, 2'b11, 1'b1);
    probe("R3 4B mask", 32'h00001000, 3'd0, 2'd1, 4'b0001);
    wr_slot(2'd0, 32'h00002005, 2'b11, 2'b10, 1'b1);
    probe("R3 8B top", 32'h00002007, 3'd0, 2'd1, 4'b0001);
    probe("R3 8B low", 32'h00002000, 3'd0, 2'd2, 4'b0001);
    probe("R3 8B past", 32'h00002008, 3'd0, 2'd1, 4'b0000);

    // R6 fetch slot
    wr_slot(2'd1, 32'h00004000, 2'b00, 2'b00, 1'b1);
    probe("R6 exact", 32'h00004000, 3'd0, 2'd0, 4'b0010);
    probe("R6 cover", 32'h00003FFF, 3'd3, 2'd0, 4'b0000);
    probe("R6 read", 32'h00004000, 3'd0, 2'd1, 4'b0000);
    wr_slot(2'd1, 32'h00004000, 2'b00, 2'b01, 1'b1);
    probe("R6 badlen", 32'h00004000, 3'd0, 2'd0, 4'b0000);

    // R7 port slot
    wr_slot(2'd2, 32'h00000060, 2'b10, 2'b00, 1'b1);
    probe("R7 zext", 32'hABCD0060, 3'd0, 2'd3, 4'b0100);
    probe("R7 read", 32'h00000060, 3'd0, 2'd1, 4'b0000);
    wr_slot(2'd2, 32'h00010060, 2'b10, 2'b00, 1'b1);
    probe("R7 high", 32'h00010060, 3'd0, 2'd3, 4'b0000);

    // R8 no wrap at top
    wr_slot(2'd3, 32'h00000000, 2'b11, 2'b00, 1'b1);
    probe("R8 nowrap", 32'hFFFFFFFE, 3'd7, 2'd1, 4'b0000);
    wr_slot(2'd3, 32'hFFFFFFFC, 2'b11, 2'b11, 1'b1);
    probe("R8 top", 32'hFFFFFFFF, 3'd7, 2'd1, 4'b1000);

    // R11 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    acc_valid = 1'b1; acc_addr = 32'hFFFFFFFD; acc_len = 3'd0; acc_kind = 2'd2;
    @(negedge clk);
    check("R11 first", {27'd0, res_valid, res_hit}, {27'd0, 1'b1, 4'b1000});
    check("R11 busy", {31'd0, acc_ready}, 32'd0);
    acc_addr = 32'h00001000; acc_kind = 2'd1;
    @(negedge clk);
    check("R11 hold", {27'd0, res_valid, res_hit}, {27'd0, 1'b1, 4'b1000});
    res_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R11 next", {27'd0, res_valid, res_hit}, {27'd0, 1'b1, 4'b0000});
    @(negedge clk);
    check("R11 drain", {27'd0, res_valid, res_hit}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule